// File: doc/BRIEF.md
# Tagged Frame Inner Checksum Rewriter

This block sits on a transmit byte stream that uses a valid/ready/last handshake in the style of AXI4-Stream. It looks at each outgoing Ethernet frame and decides whether the frame carries the fixed multicast destination used for inter-switch-link tagging. For such a frame it zeroes one byte of the destination address. It then computes a CRC-32 over the encapsulated inner frame and writes that CRC over the last four bytes of the frame. All other frames leave the block byte for byte as they came in.

The position and size of the inner region come from the frame itself. The region starts at byte offset 26, which is the 14-byte Ethernet header followed by a 12-byte tagging header. Its length is the big-endian 16-bit field at bytes 12..13 minus 16. Whether a frame is modified can only be known once its length is known. For that reason the block stores the whole frame before it sends any byte out. It accepts no input while it is sending a frame.

Top module: `efr_tag_crc_rewriter`

## Requirements
- R1: A frame whose bytes 0..5 are not 01 00 0C 00 10 00 leaves the block unchanged. It has the same length, and m_last_o is asserted on its final byte only.
- R2: In a modified frame, byte 4 leaves as 0x00. Every byte outside byte 4 and the last four bytes keeps its input value.
- R3: The inner region starts at byte 26 and is (bytes 12..13 as a big-endian value) − 16 bytes long. Its CRC is the reflected CRC-32: polynomial 0xEDB88320, seed 0xFFFFFFFF, final complement. A region of length 0 gives 0x00000000. The 9 ASCII bytes "123456789" give 0xCBF43926.
- R4: The CRC replaces the last four frame bytes, least-significant byte first.
- R5: When 26 + inner length exceeds the frame length, the frame leaves unchanged, byte 4 included.
- R6: A frame shorter than 30 bytes leaves unchanged, even when its destination matches.
- R7: A matching frame whose length field is below 16 leaves unchanged.
- R8: No output byte is offered before the last input byte of the frame has been accepted. s_ready_o is low while a frame is being sent.
- R9: While m_valid_o is high and m_ready_i is low, m_data_o and m_last_o hold their values.
- R10: A frame of 1536 bytes (parameter DEPTH) is stored and rewritten correctly.
- R11: After reset, s_ready_o is 1 and m_valid_o is 0.
- R12: When the inner region ends exactly at the frame end, the frame is modified. The CRC covers the original trailer bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_valid_i | input | 1 | Input byte valid |
| s_data_i | input | 8 | Input byte |
| s_last_i | input | 1 | Input byte is the final byte of the frame |
| s_ready_o | output | 1 | Block accepts an input byte |
| m_valid_o | output | 1 | Output byte valid |
| m_data_o | output | 8 | Output byte, rewritten where required |
| m_last_o | output | 1 | Output byte is the final byte of the frame |
| m_ready_i | input | 1 | Downstream accepts the output byte |

## Verification
The hardest cases are the ones at the edges of the rewrite decision. One is a region that ends exactly at the last byte. Others are a region one step too long, a frame one byte below the minimum, and a length field below 16. A small offset error in the RTL would still produce correct output for ordinary frames, so ordinary frames cannot expose it. The bench therefore builds frames whose length field is chosen so that each of these boundaries is hit exactly. It also checks against a known CRC vector, so the CRC is not judged only by a model of the same algorithm. Backpressure is applied in a fixed pattern during one full frame and during the maximum-size frame, so that stall cycles fall on the patched bytes.

// File: rtl/efr_pkg.sv
package efr_pkg;
  localparam logic [47:0] TAG_DST    = 48'h01_00_0C_00_10_00;
  localparam int unsigned INNER_OFS  = 26;   // 14 Ethernet + 12 tag header
  localparam int unsigned LEN_ADJ    = 16;   // tag header + 4
  localparam int unsigned FCS_BYTES  = 4;
  localparam int unsigned MIN_FRAME  = 30;
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] dst_byte(input logic [2:0] k);
    case (k)
      3'd0: return TAG_DST[47:40];
      3'd1: return TAG_DST[39:32];
      3'd2: return TAG_DST[31:24];
      3'd3: return TAG_DST[23:16];
      3'd4: return TAG_DST[15:8];
      default: return TAG_DST[7:0];
    endcase
  endfunction
endpackage

// File: rtl/efr_crc_acc.sv
module efr_crc_acc
  import efr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  logic [31:0] acc_q, acc_n;

  always_comb begin
    acc_n = start_i ? CRC_SEED : acc_q;
    if (en_i) acc_n = crc_step(acc_n, data_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) acc_q <= CRC_SEED;
    else         acc_q <= acc_n;

  assign crc_o = ~acc_q;

  p_crc_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !en_i |=> $stable(crc_o));
endmodule

// File: rtl/efr_frame_parse.sv
module efr_frame_parse
  import efr_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          beat_i,
  input  logic [AW-1:0] idx_i,
  input  logic [7:0]    data_i,
  input  logic          last_i,
  output logic          crc_start_o,
  output logic          crc_en_o,
  output logic          patch_o
);
  localparam int unsigned EW = (AW > 17) ? AW + 1 : 18;

  logic          dst_ok_q, dst_ok_cur, dst_ok_n;
  logic [15:0]   type_q;
  logic          first, type_ok, patch_q, patch_n;
  logic [EW-1:0] pos, frame_len, inner_end;

  assign first      = (idx_i == '0);
  assign dst_ok_cur = first ? 1'b1 : dst_ok_q;
  assign dst_ok_n   = dst_ok_cur &
                      ((idx_i < AW'(6)) ? (data_i == dst_byte(idx_i[2:0])) : 1'b1);
  assign pos        = EW'(idx_i);
  assign frame_len  = pos + EW'(1);
  assign inner_end  = EW'(type_q) + EW'(INNER_OFS) - EW'(LEN_ADJ);
  assign type_ok    = (type_q >= 16'(LEN_ADJ));

  assign crc_start_o = beat_i && first;
  assign crc_en_o    = beat_i && type_ok && (pos >= EW'(INNER_OFS)) && (pos < inner_end);
  assign patch_n     = dst_ok_n && type_ok && (frame_len >= EW'(MIN_FRAME)) &&
                       (inner_end <= frame_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_ok_q <= 1'b0;
      type_q   <= '0;
      patch_q  <= 1'b0;
    end else if (beat_i) begin
      dst_ok_q <= dst_ok_n;
      if (idx_i == AW'(12)) type_q[15:8] <= data_i;
      if (idx_i == AW'(13)) type_q[7:0]  <= data_i;
      if (last_i) patch_q <= patch_n;
    end
  end

  assign patch_o = patch_q;

  p_crc_in_region_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_en_o |-> idx_i >= AW'(INNER_OFS));
endmodule

// File: rtl/efr_frame_buf.sv
module efr_frame_buf #(
  parameter int unsigned DEPTH = 1536,
  parameter int unsigned AW    = 11
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i) mem_q[waddr_i] <= wdata_i;

  assign rdata_o = (raddr_i < AW'(DEPTH)) ? mem_q[raddr_i] : 8'h00;
endmodule

// File: rtl/efr_tag_crc_rewriter.sv
module efr_tag_crc_rewriter
  import efr_pkg::*;
#(
  parameter int unsigned DEPTH = 1536
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       s_valid_i,
  input  logic [7:0] s_data_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  output logic       m_valid_o,
  output logic [7:0] m_data_o,
  output logic       m_last_o,
  input  logic       m_ready_i
);
  localparam int unsigned AW = $clog2(DEPTH + 1);

  typedef enum logic {ST_FILL, ST_DRAIN} state_e;
  state_e state_q;

  logic [AW-1:0] wr_idx_q, rd_idx_q, len_q, tail_start, tail_k;
  logic [7:0]    rd_byte;
  logic [31:0]   crc;
  logic          in_beat, out_beat, crc_start, crc_en, patch, in_tail;

  assign s_ready_o = (state_q == ST_FILL);
  assign m_valid_o = (state_q == ST_DRAIN);
  assign in_beat   = s_valid_i && s_ready_o;
  assign out_beat  = m_valid_o && m_ready_i;

  efr_frame_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk_i, .we_i(in_beat), .waddr_i(wr_idx_q), .wdata_i(s_data_i),
    .raddr_i(rd_idx_q), .rdata_o(rd_byte)
  );

  efr_frame_parse #(.AW(AW)) u_parse (
    .clk_i, .rst_ni, .beat_i(in_beat), .idx_i(wr_idx_q), .data_i(s_data_i),
    .last_i(s_last_i), .crc_start_o(crc_start), .crc_en_o(crc_en), .patch_o(patch)
  );

  efr_crc_acc u_crc (
    .clk_i, .rst_ni, .start_i(crc_start), .en_i(crc_en), .data_i(s_data_i), .crc_o(crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_FILL;
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      len_q    <= '0;
    end else begin
      case (state_q)
        ST_FILL: if (in_beat) begin
          if (s_last_i) begin
            len_q    <= wr_idx_q + AW'(1);
            wr_idx_q <= '0;
            rd_idx_q <= '0;
            state_q  <= ST_DRAIN;
          end else begin
            wr_idx_q <= wr_idx_q + AW'(1);
          end
        end
        default: if (out_beat) begin
          if (m_last_o) state_q <= ST_FILL;
          rd_idx_q <= rd_idx_q + AW'(1);
        end
      endcase
    end
  end

  // trailer patch, LSB first
  assign tail_start = len_q - AW'(FCS_BYTES);
  assign in_tail    = (rd_idx_q >= tail_start);
  assign tail_k     = rd_idx_q - tail_start;

  always_comb begin
    m_data_o = rd_byte;
    if (patch) begin
      if (rd_idx_q == AW'(4)) m_data_o = 8'h00;
      else if (in_tail)       m_data_o = crc[8*tail_k[1:0] +: 8];
    end
  end

  assign m_last_o = m_valid_o && (rd_idx_q == len_q - AW'(1));

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_beat |-> wr_idx_q < AW'(DEPTH));
  p_out_after_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_beat && s_last_i |=> m_valid_o && !s_ready_o);
  p_hold_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_last_o));
  p_frame_end_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_beat && m_last_o |=> s_ready_o && !m_valid_o);
  p_patch_min_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && patch |-> len_q >= AW'(MIN_FRAME));
endmodule

// File: tb/efr_tag_crc_rewriter_tb.sv
module efr_tag_crc_rewriter_tb_top;
  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_last = 0, m_ready = 0;
  logic [7:0] s_data = 0;
  logic s_ready, m_valid, m_last;
  logic [7:0] m_data;

  always #4 clk = ~clk;  // 125 MHz

  efr_tag_crc_rewriter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .s_valid_i(s_valid), .s_data_i(s_data),
    .s_last_i(s_last), .s_ready_o(s_ready), .m_valid_o(m_valid), .m_data_o(m_data),
    .m_last_o(m_last), .m_ready_i(m_ready)
  );

  int checks = 0, bad = 0;
  logic [7:0] tx_f [0:1599];
  logic [7:0] ex_f [0:1599];
  logic [7:0] rx_f [0:1599];
  int tx_n, rx_n, last_pos, last_cnt;
  bit early, stall_err, ready_err;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(int from, int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      c ^= {24'd0, tx_f[from + i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build(bit match, int n, int typ);
    logic [47:0] d = match ? 48'h01000C001000 : 48'h01000C001001;
    tx_n = n;
    for (int i = 0; i < n; i++) tx_f[i] = 8'((i * 7 + 3) & 255);
    for (int i = 0; i < 6; i++) tx_f[i] = d[8*(5-i) +: 8];
    tx_f[12] = 8'(typ >> 8);
    tx_f[13] = 8'(typ & 255);
  endtask

  task automatic model();
    bit m = 1;
    int l;
    logic [31:0] c;
    for (int i = 0; i < tx_n; i++) ex_f[i] = tx_f[i];
    if (tx_n < 30) m = 0;
    if (!(tx_f[0] == 8'h01 && tx_f[1] == 8'h00 && tx_f[2] == 8'h0C && tx_f[3] == 8'h00 &&
          tx_f[4] == 8'h10 && tx_f[5] == 8'h00)) m = 0;
    l = {tx_f[12], tx_f[13]} - 16;
    if (l < 0 || 26 + l > tx_n) m = 0;
    if (m) begin
      c = ref_crc(26, l);
      ex_f[4] = 8'h00;
      for (int k = 0; k < 4; k++) ex_f[tx_n - 4 + k] = c[8*k +: 8];
    end
  endtask

  task automatic send();
    int i = 0;
    early = 0;
    while (i < tx_n) begin
      @(negedge clk);
      if (m_valid) early = 1;
      s_valid = 1; s_data = tx_f[i]; s_last = (i == tx_n - 1);
      if (s_ready) i++;
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 0; s_last = 0;
  endtask

  task automatic recv(bit stall);
    int cyc = 0;
    bit prev_stall = 0, done = 0;
    logic [7:0] pd = 0;
    logic pl = 0;
    rx_n = 0; last_pos = -1; last_cnt = 0; stall_err = 0; ready_err = 0;
    while (!done && cyc < 6000) begin
      @(negedge clk);
      if (prev_stall && (!m_valid || m_data != pd || m_last != pl)) stall_err = 1;
      if (m_valid && s_ready) ready_err = 1;
      m_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      #1;
      prev_stall = m_valid && !m_ready;
      pd = m_data; pl = m_last;
      if (m_valid && m_ready) begin
        rx_f[rx_n] = m_data;
        if (m_last) begin last_pos = rx_n; last_cnt++; done = 1; end
        rx_n++;
      end
      cyc++;
      @(posedge clk);
    end
    @(negedge clk);
    m_ready = 0;
  endtask

  task automatic run(string req, bit stall);
    int first_bad = -1;
    model();
    send();
    chk(!early, "R8", "output before last input", int'(early), 0);
    recv(stall);
    chk(!ready_err, "R8", "s_ready during drain", int'(ready_err), 0);
    chk(rx_n == tx_n && last_pos == tx_n - 1 && last_cnt == 1, "R1", "length/last",
        rx_n, tx_n);
    for (int i = 0; i < tx_n; i++)
      if (first_bad < 0 && rx_f[i] != ex_f[i]) first_bad = i;
    if (first_bad >= 0)
      chk(0, req, $sformatf("byte %0d", first_bad), rx_f[first_bad], ex_f[first_bad]);
    else chk(1, req, "content", 0, 0);
    if (stall) chk(!stall_err, "R9", "hold under stall", int'(stall_err), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(s_ready == 1 && m_valid == 0, "R11", "reset state", {s_ready, m_valid}, 2);
  endtask

  task automatic t_plain();
    build(0, 64, 50); run("R1", 0);
  endtask

  task automatic t_vector();
    build(1, 39, 25);
    for (int i = 0; i < 9; i++) tx_f[26 + i] = 8'h31 + 8'(i);
    run("R3", 0);
    chk(rx_f[4] == 8'h00, "R2", "dst byte 4", rx_f[4], 0);
    chk({rx_f[38], rx_f[37], rx_f[36], rx_f[35]} == 32'hCBF43926, "R4", "trailer LSB first",
        {rx_f[38], rx_f[37], rx_f[36], rx_f[35]}, 32'hCBF43926);
  endtask

  task automatic t_empty();
    build(1, 40, 16); run("R3", 0);
    chk({rx_f[36], rx_f[37], rx_f[38], rx_f[39]} == 0, "R3", "empty region crc",
        {rx_f[36], rx_f[37], rx_f[38], rx_f[39]}, 0);
  endtask

  task automatic t_exact_end();
    build(1, 80, 70); run("R12", 0);
    chk(rx_f[4] == 8'h00, "R12", "modified at exact end", rx_f[4], 0);
  endtask

  task automatic t_overrun();
    build(1, 60, 51); run("R5", 0);
    chk(rx_f[4] == 8'h10, "R5", "dst byte kept", rx_f[4], 8'h10);
  endtask

  task automatic t_short();
    build(1, 29, 19); run("R6", 0);
    chk(rx_f[4] == 8'h10, "R6", "short frame dst kept", rx_f[4], 8'h10);
  endtask

  task automatic t_badtype();
    build(1, 64, 10); run("R7", 0);
    chk(rx_f[4] == 8'h10, "R7", "low length field dst kept", rx_f[4], 8'h10);
  endtask

  task automatic t_stall();
    build(1, 100, 60); run("R9", 1);
  endtask

  task automatic t_max();
    build(1, 1536, 1526); run("R10", 1);
    build(0, 1536, 1526); run("R10", 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_plain();
    t_vector();
    t_empty();
    t_exact_end();
    t_overrun();
    t_short();
    t_badtype();
    t_stall();
    t_max();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule